// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C master running in the core clock domain. While it is enabled it alternates two phases. In the low phase it pulls SCL low for a programmed number of core cycles. In the released phase it lets SCL go and waits until the line is seen high through a synchroniser and glitch filter. It then counts the programmed high time before it pulls the line low again. A slave that holds SCL low after the release lengthens the released phase, because the high count does not start until the line is seen high.

Two pairs of high/low counts are held, one pair for standard mode and one for fast mode, and a speed input chooses the pair. A fifth count sets the SDA hold point. The bit engine beside this block receives two single-cycle strobes. One marks the cycle in which SDA may change, after the hold delay from the SCL falling edge. The other marks the cycle in which SDA is sampled, when the filtered line is first seen high. Counts that are too small for the filter latency are raised to safe minimums. Configuration writes are accepted only while the block is disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and from the cycle after `enable` falls, `scl_drive_low`, `chg_stb` and `smp_stb` are all 0.
- R2: Each low phase keeps `scl_drive_low` at 1 for exactly LCNT+1 consecutive cycles, counted from the cycle in which the block starts pulling SCL low.
- R3: When no device holds SCL low, each released phase keeps `scl_drive_low` at 0 for exactly HCNT+8 cycles: 8 cycles of synchroniser, filter and start latency plus the programmed count.
- R4: If SCL is still low S cycles into the released phase, the released phase lasts S+HCNT+8 cycles. The high count starts only after the filtered line is high.
- R5: With `fast_mode`=1 the fast-mode high and low counts are used, and with `fast_mode`=0 the standard-mode counts are used.
- R6: A high count below 6 behaves as 6, and a low count below 8 behaves as 8.
- R7: `chg_stb` pulses once per low phase, in the low-phase cycle with zero-based index HOLD. HOLD is capped at the effective low count.
- R8: `smp_stb` pulses once per released phase, in the cycle with zero-based index S+5, where S is the number of stretched cycles. It never coincides with `chg_stb`.
- R9: A configuration write while `enable`=1 has no effect, either at once or after the block is disabled.
- R10: `cfg_sel` selects the target register: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low and 4 is SDA hold. Codes 5 to 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 stops clocking and opens configuration writes |
| fast_mode | input | 1 | 1 selects the fast-mode count pair, 0 the standard-mode pair |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write value |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (open-drain control) |
| chg_stb | output | 1 | SDA may change in this cycle |
| smp_stb | output | 1 | SDA sample point in this cycle |

## Verification
The clock is run with a standard-mode pair, then a fast-mode pair, with the line following the drive at once. This separates the low count from the high count and shows that the speed input swaps both. A stretched run holds the line low for several cycles after release and shows whether the high count waits for the filtered line or starts at release. Counts below the minimums and a hold larger than the low count exercise the clamps. Writes made while enabled and writes to unused select codes are followed by clocking runs, and unchanged phase lengths show that these writes had no effect.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam int NUM_CFG      = 5;
    localparam int SEL_SS_HIGH  = 0;
    localparam int SEL_SS_LOW   = 1;
    localparam int SEL_FS_HIGH  = 2;
    localparam int SEL_FS_LOW   = 3;
    localparam int SEL_HOLD     = 4;

    localparam int MIN_HIGH_CNT = 6;
    localparam int MIN_LOW_CNT  = 8;

    // Released-phase cycles spent before the high counter begins, and the
    // total fixed overhead added on top of the programmed high count.
    localparam int HIGH_OVERHEAD = 8;
    localparam int DETECT_CYCLES = 5;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic filt;
    } line_flt_t;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RST_SS_HIGH = 40,
    parameter int RST_SS_LOW  = 47,
    parameter int RST_FS_HIGH = 6,
    parameter int RST_FS_LOW  = 13,
    parameter int RST_HOLD    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_mode,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] low_cnt,
    output logic [CNT_W-1:0] hold_cnt
);

    localparam logic [CNT_W-1:0] MIN_H = CNT_W'(MIN_HIGH_CNT);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_LOW_CNT);
    localparam logic [NUM_CFG-1:0][CNT_W-1:0] RST_VALS = {
        CNT_W'(RST_HOLD), CNT_W'(RST_FS_LOW), CNT_W'(RST_FS_HIGH),
        CNT_W'(RST_SS_LOW), CNT_W'(RST_SS_HIGH)
    };

    logic [NUM_CFG-1:0][CNT_W-1:0] regs_d, regs_q;
    logic [CNT_W-1:0] raw_high, raw_low;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (cfg_we && !enable && (cfg_sel == 3'(i))) begin
                regs_d[i] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RST_VALS;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        raw_high = fast_mode ? regs_q[SEL_FS_HIGH] : regs_q[SEL_SS_HIGH];
        raw_low  = fast_mode ? regs_q[SEL_FS_LOW]  : regs_q[SEL_SS_LOW];
        high_cnt = (raw_high < MIN_H) ? MIN_H : raw_high;
        low_cnt  = (raw_low  < MIN_L) ? MIN_L : raw_low;
        hold_cnt = (regs_q[SEL_HOLD] > low_cnt) ? low_cnt : regs_q[SEL_HOLD];
    end

    // Configuration is frozen while the controller runs.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(regs_q));

endmodule

// File: rtl/scl_line_filter.sv
module scl_line_filter
    import scl_timing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_high
);

    line_flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.s1   = scl_in;
        flt_d.s2   = flt_q.s1;
        flt_d.prev = flt_q.s2;
        if (flt_q.s2 == flt_q.prev) begin
            flt_d.filt = flt_q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, filt: 1'b1};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign scl_high = flt_q.filt;

    // The filtered level moves only after two agreeing synchronised samples.
    assert_filter_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.filt != $past(flt_q.filt)) |-> $past(flt_q.s2 == flt_q.prev));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RST_SS_HIGH = 40,
    parameter int RST_SS_LOW  = 47,
    parameter int RST_FS_HIGH = 6,
    parameter int RST_FS_LOW  = 13,
    parameter int RST_HOLD    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_mode,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             chg_stb,
    output logic             smp_stb
);

    localparam int PH_CNT_W = CNT_W + 1;
    localparam logic [PH_CNT_W-1:0] HIGH_PAD = PH_CNT_W'(HIGH_OVERHEAD - DETECT_CYCLES - 1);

    typedef struct packed {
        phase_e              phase;
        logic [PH_CNT_W-1:0] cnt;
    } fsm_t;

    logic [CNT_W-1:0] high_cnt, low_cnt, hold_cnt;
    logic             scl_high;
    logic [PH_CNT_W-1:0] high_last, low_last;
    fsm_t fsm_d, fsm_q;

    scl_cfg_regs #(
        .CNT_W(CNT_W), .RST_SS_HIGH(RST_SS_HIGH), .RST_SS_LOW(RST_SS_LOW),
        .RST_FS_HIGH(RST_FS_HIGH), .RST_FS_LOW(RST_FS_LOW), .RST_HOLD(RST_HOLD)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .high_cnt(high_cnt), .low_cnt(low_cnt), .hold_cnt(hold_cnt)
    );

    scl_line_filter u_flt (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_high(scl_high)
    );

    assign high_last = {1'b0, high_cnt} + HIGH_PAD;
    assign low_last  = {1'b0, low_cnt};

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.phase)
            PH_IDLE: begin
                fsm_d.phase = PH_LOW;
                fsm_d.cnt   = '0;
            end
            PH_LOW: begin
                if (fsm_q.cnt == low_last) begin
                    fsm_d.phase = PH_WAIT;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (scl_high) begin
                    fsm_d.phase = PH_HIGH;
                    fsm_d.cnt   = '0;
                end
            end
            PH_HIGH: begin
                if (fsm_q.cnt == high_last) begin
                    fsm_d.phase = PH_LOW;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: fsm_d = '{phase: PH_IDLE, cnt: '0};
        endcase
        if (!enable) begin
            fsm_d = '{phase: PH_IDLE, cnt: '0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign scl_drive_low = (fsm_q.phase == PH_LOW);
    assign chg_stb       = (fsm_q.phase == PH_LOW)  && (fsm_q.cnt == {1'b0, hold_cnt});
    assign smp_stb       = (fsm_q.phase == PH_HIGH) && (fsm_q.cnt == '0);

    assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low);

    assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.phase == PH_LOW) |-> (fsm_q.cnt <= low_last));

    assert_wait_for_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.phase == PH_WAIT && enable && !scl_high) |=> (fsm_q.phase != PH_HIGH));

    assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_stb && smp_stb));

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

    localparam int W = 16;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         fast_mode = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_sel = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic         scl_in;
    logic         scl_drive_low, chg_stb, smp_stb;

    int   n_checks = 0;
    int   n_err = 0;
    int   stretch_n = 0;
    int   hold_ctr = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    assign scl_in = scl_drive_low ? 1'b0 : ((hold_ctr > 0) ? 1'b0 : 1'b1);

    scl_timing_gen #(.CNT_W(W)) u_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .chg_stb(chg_stb), .smp_stb(smp_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Stretcher: a slave that keeps SCL low for stretch_n cycles after release.
    logic sprev = 1'b0;
    always @(negedge clk) begin
        if (sprev && !scl_drive_low) hold_ctr <= stretch_n;
        else if (hold_ctr > 0)       hold_ctr <= hold_ctr - 1;
        sprev <= scl_drive_low;
    end

    // Monitor: measures phase lengths and strobe offsets, compares with queue.
    // kind 0 = change strobe offset, 1 = low length, 2 = sample offset, 3 = high length
    task automatic report(input int kind, input int val);
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        check(e.kind == kind, e.req, "event kind", kind, e.kind);
        check(e.val == val, e.req, "cycles", val, e.val);
    endtask

    bit mprev = 1'b0;
    bit armed = 1'b0;
    int run = 0;
    always @(negedge clk) begin
        if (!enable) begin
            armed = 1'b0;
            run   = 0;
            mprev = scl_drive_low;
        end else begin
            if (scl_drive_low != mprev) begin
                if (armed) report(scl_drive_low ? 3 : 1, run);
                if (scl_drive_low) armed = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            if (armed && chg_stb) report(0, run - 1);
            if (armed && smp_stb) report(2, run - 1);
            mprev = scl_drive_low;
        end
    end

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'(sel);
        cfg_wdata = W'(val);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic push_periods(input int h, input int l, input int hd, input int s,
                                input int n, input string tag);
        int eh = (h < 6) ? 6 : h;
        int el = (l < 8) ? 8 : l;
        int ehd = (hd > el) ? el : hd;
        for (int i = 0; i < n; i++) begin
            q.push_back('{0, ehd, {"R7 ", tag}});
            q.push_back('{1, el + 1, {"R2 ", tag}});
            q.push_back('{2, s + 5, {"R8 ", tag}});
            q.push_back('{3, eh + 8 + s, {"R3 R4 ", tag}});
        end
    endtask

    task automatic finish_run();
        wait (q.size() == 0);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low && !chg_stb && !smp_stb, "R1", "released after disable",
              int'(scl_drive_low), 0);
    endtask

    task automatic run_periods(input int h, input int l, input int hd, input int s,
                               input int n, input string tag);
        stretch_n = s;
        push_periods(h, l, hd, s, n, tag);
        @(negedge clk);
        enable = 1'b1;
        finish_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low && !chg_stb && !smp_stb, "R1", "reset outputs",
              int'({scl_drive_low, chg_stb, smp_stb}), 0);

        // Standard mode, no stretching (R2 R3 R7 R8, R10 select codes 0/1/4)
        wr(0, 12); wr(1, 15); wr(4, 4);
        fast_mode = 1'b0;
        run_periods(12, 15, 4, 0, 3, "std R10");

        // Fast mode pair (R5, R10 select codes 2/3)
        wr(2, 7); wr(3, 9);
        fast_mode = 1'b1;
        run_periods(7, 9, 4, 0, 3, "fast R5 R10");

        // Back to standard pair with the same registers (R5)
        fast_mode = 1'b0;
        run_periods(12, 15, 4, 0, 1, "std again R5");

        // Stretched released phase (R4)
        run_periods(12, 15, 4, 6, 2, "stretch R4");
        run_periods(12, 15, 4, 1, 1, "stretch1 R4");

        // Clamps: counts below minimum, hold above low count (R6, R7)
        wr(0, 2); wr(1, 3); wr(4, 20);
        run_periods(2, 3, 20, 0, 2, "clamp R6");

        // Writes while enabled are ignored (R9)
        fast_mode = 1'b1;
        wr(4, 2);
        stretch_n = 0;
        push_periods(7, 9, 2, 0, 4, "live write R9");
        @(negedge clk);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        wr(3, 40);
        wr(2, 30);
        finish_run();
        run_periods(7, 9, 2, 0, 1, "after live write R9");

        // Unused select codes write nothing (R10)
        wr(5, 100); wr(6, 100); wr(7, 100);
        run_periods(7, 9, 2, 0, 1, "unused sel fast R10");
        fast_mode = 1'b0;
        run_periods(2, 3, 2, 0, 1, "unused sel std R10");

        // A write while disabled does take effect (R9 R10)
        fast_mode = 1'b1;
        wr(3, 20);
        run_periods(7, 20, 2, 0, 1, "disabled write R10");

        // Disable in the middle of a low phase (R1)
        @(negedge clk);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(scl_drive_low, "R1", "low phase active before disable", int'(scl_drive_low), 1);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R1", "mid-phase disable releases", int'(scl_drive_low), 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule